// File: doc/BRIEF.md
# Nonvolatile Wiper Store and Recall Sequencer

This block keeps the volatile wiper position of a 32-step digital potentiometer, together with an emulated 5-bit nonvolatile cell that survives a power cycle. It sits behind a serial command slave. The slave turns each decoded command into a single-cycle request that carries an operation code and a data value. A power-on reset clears the volatile wiper. The block then waits through a short initialization interval and copies the saved value back into the wiper, so the wiper returns to where it was last stored.

There are two ways to store: a direct value, or a copy of the present wiper. Either one opens a programming window of several milliseconds. During that window `busy` stays high and new requests are refused, so the slave can withhold acknowledge. A recall copies the saved value into the wiper. A volatile load moves the wiper at once. A request that arrives while the block is busy is dropped and raises a sticky error flag. `standby` reports that no programming or initialization is in progress. All intervals come from a clock-frequency parameter.

Top module: `nvw_wiper_seq`

## Requirements
- R1: While `rst_n` is low, `wiper` is 0, `busy` is 1, `standby` is 0 and `req_err` is 0.
- R2: After `rst_n` rises, `busy` stays high for INIT_CYC = CLK_HZ*INIT_NS/1e9 rising edges. On edge INIT_CYC the wiper takes the stored value, `busy` falls and `standby` rises.
- R3: The stored cell holds 0 before any store, and it keeps its value through any number of `rst_n` pulses.
- R4: Op code 2'b00 loads `req_data` into `wiper` on the request edge.
- R5: Op code 2'b01 stores `req_data` into the cell and leaves `wiper` unchanged. A later recall shows the new value.
- R6: Op code 2'b11 stores the wiper value held on the request edge.
- R7: Op code 2'b10 copies the stored value into `wiper` on the request edge. This holds for the extreme codes 0 and 31.
- R8: A store keeps `busy` high and `standby` low for PROG_CYC = CLK_HZ*PROG_NS/1e9 edges after the request edge. `busy` falls on edge request+PROG_CYC.
- R9: A request accepted while `busy` is high, whether during initialization or programming, has no effect on `wiper` or the cell. It sets `req_err` on the same edge, and `req_err` stays set until `rst_n` goes low.
- R10: `standby` is high exactly when `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset, models power loss |
| req_valid | input | 1 | Single-cycle request strobe |
| req_op | input | 2 | 00 load wiper, 01 store value, 10 recall, 11 store wiper |
| req_data | input | W | Value for load or direct store |
| wiper | output | W | Volatile wiper position |
| busy | output | 1 | Initialization or programming in progress |
| standby | output | 1 | Idle, no programming under way |
| req_err | output | 1 | Sticky flag: a request arrived while busy |

## Verification
Some properties are checked on every cycle by assertions. The wiper never moves while `busy` stays high. The error flag never clears. A refused request always sets it. The stored cell never changes while the block rests in standby. The end of initialization always leaves the wiper equal to the stored value. A recall always lands the stored value. Other behaviours need the bench's scenarios to show them. These are the exact window lengths, the value a copy-store captures, retention of the stored cell across a reset pulse, and the factory-zero contents.

// File: rtl/nvw_pkg.sv
package nvw_pkg;

   typedef enum logic [1:0] {
      OP_LOAD_VOL     = 2'b00,
      OP_STORE_DIRECT = 2'b01,
      OP_RECALL       = 2'b10,
      OP_STORE_COPY   = 2'b11
   } nvw_op_e;

   typedef enum logic [1:0] {
      PH_INIT = 2'd0,
      PH_IDLE = 2'd1,
      PH_PROG = 2'd2
   } nvw_phase_e;

   function automatic longint unsigned nvw_cycles(input longint unsigned hz,
                                                  input longint unsigned ns);
      return (hz * ns) / 64'd1_000_000_000;
   endfunction

endpackage

// File: rtl/nvw_interval_timer.sv
module nvw_interval_timer #(
   parameter int unsigned CW        = 8,
   parameter int unsigned RESET_LEN = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [CW-1:0] len,
   output logic          expired
);

   if (RESET_LEN < 2) begin : g_chk_len
      $error("nvw_interval_timer: RESET_LEN must be at least 2");
   end

   logic [CW-1:0] cnt_q;
   logic          running_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q     <= CW'(RESET_LEN - 1);
         running_q <= 1'b1;
      end else if (start) begin
         cnt_q     <= len;
         running_q <= 1'b1;
      end else if (running_q) begin
         if (cnt_q == '0) running_q <= 1'b0;
         else             cnt_q     <= cnt_q - CW'(1);
      end
   end

   assign expired = running_q && (cnt_q == '0);

   assert_timer_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (running_q && cnt_q != '0 && !start) |=> (running_q && cnt_q == $past(cnt_q) - CW'(1)));

endmodule

// File: rtl/nvw_nv_cell.sv
module nvw_nv_cell #(
   parameter int unsigned W = 5
) (
   input  logic         clk,
   input  logic         we,
   input  logic [W-1:0] wd,
   output logic [W-1:0] q
);

   if (W < 1) begin : g_chk_w
      $error("nvw_nv_cell: W must be at least 1");
   end

   // No reset: contents survive power loss; factory contents are zero.
   logic [W-1:0] cell_q = '0;

   always_ff @(posedge clk) begin
      if (we) cell_q <= wd;
   end

   assign q = cell_q;

endmodule

// File: rtl/nvw_wiper_seq.sv
module nvw_wiper_seq
   import nvw_pkg::*;
#(
   parameter int unsigned      W             = 5,
   parameter longint unsigned  CLK_HZ        = 125_000_000,
   parameter longint unsigned  INIT_NS       = 20_000,
   parameter longint unsigned  PROG_NS       = 12_000_000,
   parameter bit               COMMIT_AT_END = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         req_valid,
   input  logic [1:0]   req_op,
   input  logic [W-1:0] req_data,
   output logic [W-1:0] wiper,
   output logic         busy,
   output logic         standby,
   output logic         req_err
);

   localparam int unsigned INIT_CYC = int'(nvw_cycles(CLK_HZ, INIT_NS));
   localparam int unsigned PROG_CYC = int'(nvw_cycles(CLK_HZ, PROG_NS));
   localparam int unsigned MAX_CYC  = (INIT_CYC > PROG_CYC) ? INIT_CYC : PROG_CYC;
   localparam int unsigned CW       = $clog2(MAX_CYC + 1);

   if (W < 1 || W > 16) begin : g_chk_w
      $error("nvw_wiper_seq: W out of range");
   end
   if (INIT_CYC < 2) begin : g_chk_init
      $error("nvw_wiper_seq: initialization interval shorter than two cycles");
   end
   if (PROG_CYC < 2) begin : g_chk_prog
      $error("nvw_wiper_seq: programming interval shorter than two cycles");
   end

   nvw_phase_e   phase_q;
   logic [W-1:0] wiper_q;
   logic [W-1:0] pend_q;
   logic         err_q;
   logic [W-1:0] nv_q;
   logic         expired;
   logic         store_go;
   logic         prog_done;
   logic [W-1:0] store_val;
   logic         cell_we;
   logic [W-1:0] cell_wd;
   nvw_op_e      op;

   assign op        = nvw_op_e'(req_op);
   assign store_go  = (phase_q == PH_IDLE) && req_valid &&
                      (op == OP_STORE_DIRECT || op == OP_STORE_COPY);
   assign store_val = (op == OP_STORE_DIRECT) ? req_data : wiper_q;
   assign prog_done = (phase_q == PH_PROG) && expired;

   nvw_interval_timer #(
      .CW        (CW),
      .RESET_LEN (INIT_CYC)
   ) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (store_go),
      .len     (CW'(PROG_CYC - 1)),
      .expired (expired)
   );

   if (COMMIT_AT_END) begin : g_commit_end
      assign cell_we = prog_done;
      assign cell_wd = pend_q;
   end else begin : g_commit_start
      assign cell_we = store_go;
      assign cell_wd = store_val;
   end

   nvw_nv_cell #(
      .W (W)
   ) u_cell (
      .clk (clk),
      .we  (cell_we),
      .wd  (cell_wd),
      .q   (nv_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_INIT;
         wiper_q <= '0;
         pend_q  <= '0;
         err_q   <= 1'b0;
      end else begin
         unique case (phase_q)
            PH_INIT: begin
               if (req_valid) err_q <= 1'b1;
               if (expired) begin
                  wiper_q <= nv_q;
                  phase_q <= PH_IDLE;
               end
            end
            PH_IDLE: begin
               if (req_valid) begin
                  unique case (op)
                     OP_LOAD_VOL: wiper_q <= req_data;
                     OP_RECALL:   wiper_q <= nv_q;
                     OP_STORE_DIRECT, OP_STORE_COPY: begin
                        pend_q  <= store_val;
                        phase_q <= PH_PROG;
                     end
                     default: ;
                  endcase
               end
            end
            PH_PROG: begin
               if (req_valid) err_q <= 1'b1;
               if (expired) phase_q <= PH_IDLE;
            end
            default: phase_q <= PH_IDLE;
         endcase
      end
   end

   assign wiper   = wiper_q;
   assign busy    = (phase_q != PH_IDLE);
   assign standby = (phase_q == PH_IDLE);
   assign req_err = err_q;

   assert_wiper_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(wiper));

   assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $past(req_err) |-> req_err);

   assert_refused_flags_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && busy) |=> req_err);

   assert_cell_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (standby && $past(standby)) |-> $stable(nv_q));

   assert_init_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(busy) && $past(phase_q == PH_INIT)) |-> (wiper == nv_q));

   assert_recall_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (standby && req_valid && req_op == 2'b10) |=> (wiper == $past(nv_q)));

endmodule

// File: tb/test_nvw_wiper_seq.sv
module test_nvw_wiper_seq;

   localparam longint unsigned CLK_HZ = 500_000;
   localparam int INIT_CYC = int'((CLK_HZ * 64'd20_000) / 64'd1_000_000_000);
   localparam int PROG_CYC = int'((CLK_HZ * 64'd12_000_000) / 64'd1_000_000_000);

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       req_valid = 1'b0;
   logic [1:0] req_op = 2'b00;
   logic [4:0] req_data = '0;
   logic [4:0] wiper;
   logic       busy, standby, req_err;

   int total = 0;
   int bad   = 0;
   int cyc;

   typedef struct {
      int         cyc;
      logic [4:0] w;
      logic       b;
      logic       s;
      logic       e;
      string      tag;
   } exp_t;
   exp_t sb[$];

   always #4 clk = ~clk;

   always @(posedge clk or negedge rst_n)
      if (!rst_n) cyc <= 0;
      else        cyc <= cyc + 1;

   nvw_wiper_seq #(.W(5), .CLK_HZ(CLK_HZ)) i_nvw_wiper_seq (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
      .req_data(req_data), .wiper(wiper), .busy(busy), .standby(standby),
      .req_err(req_err)
   );

   function automatic void chk(exp_t x);
      total++;
      if (wiper !== x.w || busy !== x.b || standby !== x.s || req_err !== x.e) begin
         bad++;
         $display("FAIL %s at cycle %0d: got w=%0d b=%0b s=%0b e=%0b expected w=%0d b=%0b s=%0b e=%0b",
                  x.tag, cyc, wiper, busy, standby, req_err, x.w, x.b, x.s, x.e);
      end
   endfunction

   function automatic void push(int c, logic [4:0] w, logic b, logic s, logic e, string tag);
      exp_t x;
      x.cyc = c; x.w = w; x.b = b; x.s = s; x.e = e; x.tag = tag;
      sb.push_back(x);
   endfunction

   // monitor: compare each expected item in the cycle it names
   always @(negedge clk) begin
      while (rst_n && sb.size() > 0 && sb[0].cyc <= cyc) begin
         chk(sb[0]);
         void'(sb.pop_front());
      end
   end

   task automatic issue(input logic [1:0] op, input logic [4:0] d,
                        input logic [4:0] ew, input logic eb, input logic es,
                        input logic ee, input string tag, output int k);
      @(negedge clk);
      k = cyc + 1;
      push(k, ew, eb, es, ee, tag);
      req_valid = 1'b1; req_op = op; req_data = d;
      @(negedge clk);
      req_valid = 1'b0; req_data = '0;
   endtask

   task automatic wait_cyc(input int n);
      while (cyc < n || sb.size() > 0) @(negedge clk);
   endtask

   logic [4:0] exp_nv;

   task automatic power_up(input bit poke);
      exp_t r;
      int   k;
      logic e;
      while (sb.size() > 0) @(negedge clk);
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      r.cyc = 0; r.w = 5'd0; r.b = 1'b1; r.s = 1'b0; r.e = 1'b0;
      r.tag = "R1 reset state";
      chk(r);
      rst_n = 1'b1;
      e = 1'b0;
      if (poke) begin
         e = 1'b1;
         issue(2'b00, 5'd9, 5'd0, 1'b1, 1'b0, 1'b1, "R9 request during init refused", k);
      end
      push(INIT_CYC - 1, 5'd0, 1'b1, 1'b0, e, "R2 still initializing");
      push(INIT_CYC, exp_nv, 1'b0, 1'b1, e, "R2 R3 init loads stored value");
      wait_cyc(INIT_CYC + 1);
   endtask

   initial begin
      int k;
      exp_nv = 5'd0;
      power_up(1'b0);                                   // R3 factory zeros

      issue(2'b00, 5'd19, 5'd19, 1'b0, 1'b1, 1'b0, "R4 volatile load", k);

      // copy-store of 19; a load during the window is refused
      issue(2'b11, 5'd0, 5'd19, 1'b1, 1'b0, 1'b0, "R8 R10 copy-store starts window", k);
      begin
         int k2;
         issue(2'b00, 5'd5, 5'd19, 1'b1, 1'b0, 1'b1, "R9 load during programming refused", k2);
      end
      push(k + PROG_CYC - 1, 5'd19, 1'b1, 1'b0, 1'b1, "R8 window last busy cycle");
      push(k + PROG_CYC, 5'd19, 1'b0, 1'b1, 1'b1, "R8 R10 window ends");
      wait_cyc(k + PROG_CYC + 1);
      exp_nv = 5'd19;

      issue(2'b00, 5'd2, 5'd2, 1'b0, 1'b1, 1'b1, "R4 volatile load", k);
      issue(2'b10, 5'd0, 5'd19, 1'b0, 1'b1, 1'b1, "R6 recall shows captured value", k);

      // direct store of max code; wiper untouched
      issue(2'b01, 5'd31, 5'd19, 1'b1, 1'b0, 1'b1, "R5 direct store leaves wiper", k);
      push(k + PROG_CYC, 5'd19, 1'b0, 1'b1, 1'b1, "R5 R8 direct store window ends");
      wait_cyc(k + PROG_CYC + 1);
      exp_nv = 5'd31;
      issue(2'b10, 5'd0, 5'd31, 1'b0, 1'b1, 1'b1, "R7 recall max code", k);

      issue(2'b00, 5'd7, 5'd7, 1'b0, 1'b1, 1'b1, "R4 volatile load", k);
      power_up(1'b1);                                   // R3 retention, R9 init refusal

      // direct store of zero, then recall of zero
      issue(2'b00, 5'd12, 5'd12, 1'b0, 1'b1, 1'b1, "R4 volatile load", k);
      issue(2'b01, 5'd0, 5'd12, 1'b1, 1'b0, 1'b1, "R5 direct store of zero", k);
      push(k + PROG_CYC, 5'd12, 1'b0, 1'b1, 1'b1, "R8 window ends");
      wait_cyc(k + PROG_CYC + 1);
      exp_nv = 5'd0;
      issue(2'b10, 5'd0, 5'd0, 1'b0, 1'b1, 1'b1, "R7 recall zero code", k);
      wait_cyc(0);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog expired: got running expected finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule